// File: doc/BRIEF.md
# Switch Hardware Reset Sequencer

This block creates the power-on reset waveform for an external Ethernet switch device on boards that lack their own reset circuit. When `start` is pulsed while the block is idle, it drives the reset-control pin through three timed phases: high, then low, then high again. While reset is low, it presets the serial clock pin high and the serial data pin low. The device samples these two levels as its default strap configuration when reset rises.

When the last high phase ends, the block stops driving the serial clock, data and chip-select pins, so those pins go to high impedance. It keeps driving reset high and raises `done` for one cycle. The register-access master can then issue its configuration writes.

A board that has no reset-control pin sets `bypass` together with `start`. The block then signals `done` at once and drives no pin. Each phase length is a parameter counted in system clock cycles, so a testbench can use short values.

Top module: `switch_reset_seq`

## Requirements
- R1: After reset, every pin enable (`rcOe`, `csOe`, `sclkOe`, `sdatOe`) is 0, every pin value is 0, and `done` is 0.
- R2: When `start` is sampled high in idle with `bypass` low, the next edge sets `rcOe`=1 and `rcOut`=1 and holds them for exactly HI1_CYC cycles. For the whole sequence, `csOe`=1 with `csOut`=0.
- R3: After the first high phase, `rcOut` is 0 for exactly LOW_CYC cycles.
- R4: The strap levels (`sclkOe`=1, `sclkOut`=1, `sdatOe`=1, `sdatOut`=0) start STRAP_LEAD_CYC cycles before the low phase ends. They hold through the final high phase. Before that point, `sclkOe` and `sdatOe` are 0.
- R5: After the low phase, `rcOut` is 1 for exactly HI2_CYC cycles. In the next cycle, `done` is 1 and the chip-select, clock and data enables and values all return to 0.
- R6: After completion, `rcOe`=1 and `rcOut`=1 remain until a later start.
- R7: A `start` sampled while the sequence runs, or in the cycle that `done` is high, has no effect: timing is unchanged and no extra `done` appears.
- R8: When `start` and `bypass` are sampled high together in idle, `done` is 1 in the next cycle and no pin output changes.
- R9: `done` is high for exactly one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run the sequence |
| bypass | input | 1 | Skip the waveform and report done at once |
| rcOut | output | 1 | Reset-control pin value |
| rcOe | output | 1 | Reset-control pin output enable |
| csOut | output | 1 | Chip-select pin value |
| csOe | output | 1 | Chip-select pin output enable |
| sclkOut | output | 1 | Serial clock pin value |
| sclkOe | output | 1 | Serial clock pin output enable |
| sdatOut | output | 1 | Serial data pin value |
| sdatOe | output | 1 | Serial data pin output enable |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a `start` that lands in the single cycle where `done` is high. At that point the sequence is finished, but the block must not yet accept a new run. The bench waits until its expected-value queue has drained past the completion cycle. It then raises `start` so that the signal is sampled exactly on that edge, and checks that no second sequence and no second pulse follow. Other `start` pulses, some carrying `bypass`, are injected during the first high phase and the low phase. The bench compares every cycle of the waveform against the expected values queued from the phase lengths, so any timing shift shows up.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HI1,
    ST_LOW,
    ST_HI2,
    ST_DONE
  } seqState_t;

  // Strobes from the control FSM to the timing/pin datapath
  typedef struct packed {
    logic enterHi1;
    logic enterLow;
    logic enterHi2;
    logic strapOn;
    logic finish;
    logic bypassDone;
  } seqStrobe_t;

endpackage

// File: rtl/swrst_ctrl.sv
module swrst_ctrl
  import swrst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       bypass,
  input  logic       cntZero,
  input  logic       strapPoint,
  output seqStrobe_t strb
);

  seqState_t state, nxtState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  always_comb begin
    strb     = '0;
    nxtState = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (bypass) begin
            strb.bypassDone = 1'b1;
            nxtState        = ST_DONE;
          end else begin
            strb.enterHi1 = 1'b1;
            nxtState      = ST_HI1;
          end
        end
      end
      ST_HI1: begin
        if (cntZero) begin
          strb.enterLow = 1'b1;
          nxtState      = ST_LOW;
        end
      end
      ST_LOW: begin
        if (strapPoint) strb.strapOn = 1'b1;
        if (cntZero) begin
          strb.enterHi2 = 1'b1;
          nxtState      = ST_HI2;
        end
      end
      ST_HI2: begin
        if (cntZero) begin
          strb.finish = 1'b1;
          nxtState    = ST_DONE;
        end
      end
      ST_DONE: nxtState = ST_IDLE;
      default: nxtState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/swrst_path.sv
module swrst_path
  import swrst_pkg::*;
#(
  parameter int HI1_CYC        = 1_000_000,
  parameter int LOW_CYC        = 5_000_000,
  parameter int HI2_CYC        = 1_500_000,
  parameter int STRAP_LEAD_CYC = 2_500_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  output logic       cntZero,
  output logic       strapPoint,
  output logic       rcOut,
  output logic       rcOe,
  output logic       csOut,
  output logic       csOe,
  output logic       sclkOut,
  output logic       sclkOe,
  output logic       sdatOut,
  output logic       sdatOe,
  output logic       done
);

  localparam int MAX_A   = (HI1_CYC > HI2_CYC) ? HI1_CYC : HI2_CYC;
  localparam int MAX_CYC = (MAX_A > LOW_CYC) ? MAX_A : LOW_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] HI1_LD   = CNT_W'(HI1_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_LD   = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] HI2_LD   = CNT_W'(HI2_CYC - 1);
  localparam logic [CNT_W-1:0] STRAP_AT = CNT_W'(STRAP_LEAD_CYC);

  logic [CNT_W-1:0] phaseCnt;

  // Shared down-counter: reloaded on each phase entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  phaseCnt <= '0;
    else if (strb.enterHi1)     phaseCnt <= HI1_LD;
    else if (strb.enterLow)     phaseCnt <= LOW_LD;
    else if (strb.enterHi2)     phaseCnt <= HI2_LD;
    else if (phaseCnt != '0)    phaseCnt <= phaseCnt - 1'b1;
  end

  assign cntZero    = (phaseCnt == '0);
  assign strapPoint = (phaseCnt == STRAP_AT);

  // Reset-control pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rcOe  <= 1'b0;
      rcOut <= 1'b0;
    end else if (strb.enterHi1) begin
      rcOe  <= 1'b1;
      rcOut <= 1'b1;
    end else if (strb.enterLow) begin
      rcOut <= 1'b0;
    end else if (strb.enterHi2) begin
      rcOut <= 1'b1;
    end
  end

  // Chip select held deasserted while the device is being reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csOe  <= 1'b0;
      csOut <= 1'b0;
    end else if (strb.enterHi1) begin
      csOe  <= 1'b1;
      csOut <= 1'b0;
    end else if (strb.finish) begin
      csOe  <= 1'b0;
      csOut <= 1'b0;
    end
  end

  // Strap presets on serial clock and data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkOe  <= 1'b0;
      sclkOut <= 1'b0;
      sdatOe  <= 1'b0;
      sdatOut <= 1'b0;
    end else if (strb.strapOn) begin
      sclkOe  <= 1'b1;
      sclkOut <= 1'b1;
      sdatOe  <= 1'b1;
      sdatOut <= 1'b0;
    end else if (strb.finish) begin
      sclkOe  <= 1'b0;
      sclkOut <= 1'b0;
      sdatOe  <= 1'b0;
      sdatOut <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= strb.finish | strb.bypassDone;
  end

endmodule

// File: rtl/switch_reset_seq.sv
module switch_reset_seq
  import swrst_pkg::*;
#(
  parameter int HI1_CYC        = 1_000_000,
  parameter int LOW_CYC        = 5_000_000,
  parameter int HI2_CYC        = 1_500_000,
  parameter int STRAP_LEAD_CYC = 2_500_000   // 1 <= value < LOW_CYC
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic bypass,
  output logic rcOut,
  output logic rcOe,
  output logic csOut,
  output logic csOe,
  output logic sclkOut,
  output logic sclkOe,
  output logic sdatOut,
  output logic sdatOe,
  output logic done
);

  seqStrobe_t strb;
  logic       cntZero;
  logic       strapPoint;

  swrst_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .bypass     (bypass),
    .cntZero    (cntZero),
    .strapPoint (strapPoint),
    .strb       (strb)
  );

  swrst_path #(
    .HI1_CYC        (HI1_CYC),
    .LOW_CYC        (LOW_CYC),
    .HI2_CYC        (HI2_CYC),
    .STRAP_LEAD_CYC (STRAP_LEAD_CYC)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cntZero    (cntZero),
    .strapPoint (strapPoint),
    .rcOut      (rcOut),
    .rcOe       (rcOe),
    .csOut      (csOut),
    .csOe       (csOe),
    .sclkOut    (sclkOut),
    .sclkOe     (sclkOe),
    .sdatOut    (sdatOut),
    .sdatOe     (sdatOe),
    .done       (done)
  );

endmodule

// File: rtl/swrst_chk.sv
module swrst_chk (
  input logic clk,
  input logic rstN,
  input logic rcOut,
  input logic rcOe,
  input logic csOut,
  input logic csOe,
  input logic sclkOut,
  input logic sclkOe,
  input logic sdatOut,
  input logic sdatOe,
  input logic done
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R9

  AST_DONE_RELEASES_PINS: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!csOe && !sclkOe && !sdatOe));  // R5

  AST_STRAP_LEVELS: assert property (@(posedge clk) disable iff (!rstN)
    sclkOe |-> (sclkOut && sdatOe && !sdatOut));  // R4

  AST_STRAP_STARTS_IN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkOe) |-> (rcOe && !rcOut));  // R4

  AST_LOW_HOLDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    (rcOe && !rcOut) |-> (csOe && !csOut));  // R3

  AST_RC_STAYS_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(rcOe));  // R6

endmodule

bind switch_reset_seq swrst_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .rcOut   (rcOut),
  .rcOe    (rcOe),
  .csOut   (csOut),
  .csOe    (csOe),
  .sclkOut (sclkOut),
  .sclkOe  (sclkOe),
  .sdatOut (sdatOut),
  .sdatOe  (sdatOe),
  .done    (done)
);

// File: tb/switch_reset_seq_tb.sv
module switch_reset_seq_tb;

  localparam int H1 = 6;
  localparam int LW = 10;
  localparam int H2 = 5;
  localparam int SL = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic bypass = 1'b0;
  logic rcOut, rcOe, csOut, csOe, sclkOut, sclkOe, sdatOut, sdatOe, done;

  always #10 clk = ~clk;

  switch_reset_seq #(
    .HI1_CYC(H1), .LOW_CYC(LW), .HI2_CYC(H2), .STRAP_LEAD_CYC(SL)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .bypass(bypass),
    .rcOut(rcOut), .rcOe(rcOe), .csOut(csOut), .csOe(csOe),
    .sclkOut(sclkOut), .sclkOe(sclkOe), .sdatOut(sdatOut), .sdatOe(sdatOe),
    .done(done)
  );

  // Vector order: rcOe rcOut csOe csOut sclkOe sclkOut sdatOe sdatOut done
  typedef struct {
    logic [8:0] pins;
    string      tag;
  } expItem_t;

  expItem_t   expQ[$];
  expItem_t   curItem;
  logic [8:0] idleVec = '0;
  string      idleTag = "R1 reset/idle";
  int         checks = 0;
  int         fails = 0;
  bit         finished = 1'b0;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Monitor: sample 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (!finished) begin
      if (expQ.size() > 0) curItem = expQ.pop_front();
      else begin
        curItem.pins = idleVec;
        curItem.tag  = idleTag;
      end
      checks++;
      if ({rcOe, rcOut, csOe, csOut, sclkOe, sclkOut, sdatOe, sdatOut, done} !== curItem.pins) begin
        fails++;
        $display("FAIL %s got=%b exp=%b at %0t", curItem.tag,
                 {rcOe, rcOut, csOe, csOut, sclkOe, sclkOut, sdatOe, sdatOut, done},
                 curItem.pins, $time);
      end
    end
  end

  task automatic pushRun();
    expItem_t it;
    for (int j = 1; j <= H1 + LW + H2 + 1; j++) begin
      bit lowPh = (j > H1) && (j <= H1 + LW);
      bit strap = (j > H1 + LW - SL) && (j <= H1 + LW + H2);
      bit fin   = (j == H1 + LW + H2 + 1);
      it.pins = {1'b1, !lowPh, !fin, 1'b0, strap, strap, strap, 1'b0, fin};
      if (fin)                it.tag = "R5 done and release";
      else if (j <= H1)       it.tag = "R2 first high phase";
      else if (lowPh && strap) it.tag = "R4 strap in low phase";
      else if (lowPh)         it.tag = "R3 low phase";
      else                    it.tag = "R5 final high phase";
      expQ.push_back(it);
    end
    idleVec = 9'b110000000;
    idleTag = "R6 reset held high after run";
  endtask

  task automatic doRun(input bit pokes);
    expItem_t it;
    @(negedge clk);
    start  = 1'b1;
    bypass = 1'b0;
    pushRun();
    @(negedge clk);
    start = 1'b0;
    if (pokes) begin
      // R7: start with bypass during first high phase
      repeat (2) @(negedge clk);
      start = 1'b1; bypass = 1'b1;
      @(negedge clk);
      start = 1'b0; bypass = 1'b0;
      // R7: start during low phase
      repeat (H1) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (expQ.size() > 0) @(negedge clk);
    if (pokes) begin
      // R7: start sampled on the edge where done is high
      start = 1'b1;
      it.pins = idleVec; it.tag = "R7 start ignored in done cycle";
      expQ.push_back(it);
      expQ.push_back(it);
      @(negedge clk);
      start = 1'b0;
      while (expQ.size() > 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic doBypass();
    expItem_t it;
    @(negedge clk);
    start  = 1'b1;
    bypass = 1'b1;
    it.pins = idleVec | 9'b000000001; it.tag = "R8 bypass done pulse";
    expQ.push_back(it);
    it.pins = idleVec; it.tag = "R9 done single cycle after bypass";
    expQ.push_back(it);
    @(negedge clk);
    start  = 1'b0;
    bypass = 1'b0;
    while (expQ.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    doBypass();      // R8 from reset idle, pins stay released
    doRun(1'b0);     // R2 R3 R4 R5 R6
    doRun(1'b1);     // R7 with pokes
    doBypass();      // R8 with reset held high
    doRun(1'b0);     // R2 rerun from held state
    finished = 1'b1;
    summary();
  end

  initial begin
    #(20 * 100_000);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog expired got=running exp=finished");
      summary();
    end
  end

endmodule